// File: doc/BRIEF.md
# PC-Relative Address Generator

This block works out what an instruction observes when it reads the program counter, and where a PC-relative literal access lands. It serves two instruction-set states. In the fixed-width state every instruction is 32 bits long. In the compressed state 16-bit and 32-bit encodings are mixed. The caller presents an instruction address, the state, the kind of access, a 12-bit unsigned immediate and an add/subtract flag. One cycle later the block returns the PC read value, the literal effective address, the link value and an alignment fault flag.

In the compressed state the PC offset is fixed: it does not depend on whether the current encoding is 16 or 32 bits long. Literal addressing always starts from a word-aligned copy of the PC read value. The subtract path can therefore reach any byte, including bytes that lie before the aligned base. Instruction decode, memory access and pipeline control are outside this block.

Top module: `pcrel_addr_gen`

## Requirements
- R1: With `in_narrow`=0 (fixed-width state), `out_pc` equals the instruction address plus 8.
- R2: With `in_narrow`=1 (compressed state), `out_pc` equals the instruction address plus 4, with no dependence on instruction length.
- R3: With `in_kind`=1 (literal), `out_addr` is the PC read value with bits [1:0] cleared, plus `in_imm` when `in_sub`=0 or minus `in_imm` when `in_sub`=1. This applies in both states. Example: compressed state at 0x15A0 with a subtracted 1 gives 0x15A3.
- R4: With `in_kind` set to 0 (register read), 2 (link) or 3 (reserved, handled as a register read), `out_addr` is zero.
- R5: With `in_kind`=2 (link), `out_link` is the compressed-state PC read value with bit 0 set. In the fixed-width state it is the instruction address plus 4 with bit 0 cleared. For every other kind `out_link` is zero.
- R6: `out_fault` is 1 when, in the fixed-width state, address bits [1:0] are nonzero, or when, in the compressed state, address bit 0 is 1. Otherwise it is 0.
- R7: All address arithmetic wraps modulo 2^32.
- R8: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1, and the results for that request are on the outputs in that same cycle.
- R9: `rst_n` is an active-low synchronous reset. It clears `out_valid`, and a request presented during reset does not raise `out_valid`.
- R10: While `in_valid` is 0, the data outputs keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 32 | Address of the current instruction |
| in_narrow | input | 1 | 1 = compressed state, 0 = fixed-width state |
| in_kind | input | 2 | 0 register read, 1 literal, 2 link, 3 reserved |
| in_imm | input | 12 | Unsigned literal offset |
| in_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| out_valid | output | 1 | Results valid |
| out_pc | output | 32 | PC read value |
| out_addr | output | 32 | Literal effective address |
| out_link | output | 32 | Link value |
| out_fault | output | 1 | Instruction address misaligned for the state |

## Verification
The bench crosses a set of instruction addresses with both states, all four access kinds, both offset directions and a spread of immediates. The addresses are halfword-aligned, word-aligned, odd and just below the top of the address space. Halfword-aligned addresses in the compressed state separate "align the PC, then add" from "add, then align". Subtracting small offsets shows that results below the aligned base stay byte-granular. Addresses near the top exercise the wrap. Odd and halfword addresses in each state separate the two fault rules. Idle cycles with scrambled inputs, and a request made during reset, confirm the hold and reset behaviour.

// File: rtl/pcrel_pkg.sv
// Shared types for the PC-relative address generator.
package pcrel_pkg;
    // Access kind carried on in_kind; the reserved code acts as a register read.
    typedef enum logic [1:0] {
        ACC_REG  = 2'd0,
        ACC_LIT  = 2'd1,
        ACC_LINK = 2'd2,
        ACC_RSVD = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/pcrel_pc_view.sv
// Computes the PC value an instruction reads: address plus a fixed offset chosen by state.
// Assumes both offsets fit in ADDR_W bits; the sum wraps.
module pcrel_pc_view #(
    parameter int ADDR_W     = 32,
    parameter int OFS_WIDE   = 8,
    parameter int OFS_NARROW = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              narrow,
    output logic [ADDR_W-1:0] pc_val
);
    localparam logic [ADDR_W-1:0] WIDE_K   = ADDR_W'(OFS_WIDE);
    localparam logic [ADDR_W-1:0] NARROW_K = ADDR_W'(OFS_NARROW);

    // Single adder with a state-selected constant.
    always_comb begin
        pc_val = addr + (narrow ? NARROW_K : WIDE_K);
    end
endmodule

// File: rtl/pcrel_lit_calc.sv
// Literal effective address: word-align the PC read value, then add or subtract the immediate.
// Assumes WORD_BYTES is a power of two and IMM_W < ADDR_W.
module pcrel_lit_calc #(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 12,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              sub,
    output logic [ADDR_W-1:0] eff
);
    localparam int LOW_BITS = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ofs;

    // Align first, then apply the signed-direction offset (wraps).
    always_comb begin
        base = pc_val & ALIGN_MASK;
        ofs  = {{(ADDR_W-IMM_W){1'b0}}, imm};
        eff  = sub ? (base - ofs) : (base + ofs);
    end

    // LOW_BITS documents the alignment width; keep it referenced for readers.
    if (LOW_BITS < 1) begin : g_bad_word
        initial $display("pcrel_lit_calc: WORD_BYTES below 2 disables alignment");
    end
endmodule

// File: rtl/pcrel_link_calc.sv
// Link value: compressed state takes the PC read with bit 0 set as a state mark;
// fixed-width state takes the next instruction address with bit 0 clear.
module pcrel_link_calc #(
    parameter int ADDR_W   = 32,
    parameter int LINK_ADV = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic              narrow,
    output logic [ADDR_W-1:0] link
);
    localparam logic [ADDR_W-1:0] ADV_K = ADDR_W'(LINK_ADV);

    // Pick the source by state and stamp bit 0 with the state.
    always_comb begin
        if (narrow) begin
            link = pc_val | ADDR_W'(1);
        end else begin
            link = (addr + ADV_K) & ~ADDR_W'(1);
        end
    end
endmodule

// File: rtl/pcrel_addr_gen.sv
// Top: registered PC-read / literal-address / link generator for two instruction-set states.
// One request per cycle, results one cycle later under out_valid. Synchronous active-low reset
// clears out_valid only; the data registers load on in_valid and hold otherwise.
module pcrel_addr_gen
    import pcrel_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 12,
    parameter int OFS_WIDE   = 8,
    parameter int OFS_NARROW = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_narrow,
    input  logic [1:0]        in_kind,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic              in_sub,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_pc,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] out_link,
    output logic              out_fault
);
    localparam int WIDE_LOW = $clog2(WORD_BYTES);

    acc_kind_e         kind;
    logic [ADDR_W-1:0] pc_c;
    logic [ADDR_W-1:0] eff_c;
    logic [ADDR_W-1:0] link_c;
    logic [ADDR_W-1:0] addr_sel;
    logic [ADDR_W-1:0] link_sel;
    logic              fault_c;

    pcrel_pc_view #(
        .ADDR_W(ADDR_W), .OFS_WIDE(OFS_WIDE), .OFS_NARROW(OFS_NARROW)
    ) pc_view_i (
        .addr(in_addr), .narrow(in_narrow), .pc_val(pc_c)
    );

    pcrel_lit_calc #(
        .ADDR_W(ADDR_W), .IMM_W(IMM_W), .WORD_BYTES(WORD_BYTES)
    ) lit_calc_i (
        .pc_val(pc_c), .imm(in_imm), .sub(in_sub), .eff(eff_c)
    );

    pcrel_link_calc #(
        .ADDR_W(ADDR_W), .LINK_ADV(OFS_WIDE - OFS_NARROW)
    ) link_calc_i (
        .addr(in_addr), .pc_val(pc_c), .narrow(in_narrow), .link(link_c)
    );

    // Decode the kind and gate the per-kind results.
    always_comb begin
        kind     = acc_kind_e'(in_kind);
        addr_sel = (kind == ACC_LIT)  ? eff_c  : '0;
        link_sel = (kind == ACC_LINK) ? link_c : '0;
    end

    // Alignment fault: full word in the fixed-width state, halfword in the compressed state.
    always_comb begin
        if (in_narrow) begin
            fault_c = in_addr[0];
        end else begin
            fault_c = |in_addr[WIDE_LOW-1:0];
        end
    end

    // Valid flag with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Result registers load on each accepted request.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_pc    <= pc_c;
            out_addr  <= addr_sel;
            out_link  <= link_sel;
            out_fault <= fault_c;
        end
    end
endmodule

// File: rtl/pcrel_addr_gen_chk.sv
// Checker for pcrel_addr_gen: timing of valid, per-state PC offset, kind gating, faults, hold.
module pcrel_addr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              in_narrow,
    input logic [1:0]        in_kind,
    input logic [IMM_W-1:0]  in_imm,
    input logic              in_sub,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_pc,
    input logic [ADDR_W-1:0] out_addr,
    input logic [ADDR_W-1:0] out_link,
    input logic              out_fault
);
    assert_wide_ofs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_narrow) |=> (out_pc == $past(in_addr) + ADDR_W'(8)));

    assert_narrow_ofs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_narrow) |=> (out_pc == $past(in_addr) + ADDR_W'(4)));

    assert_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind != 2'd1) |=> (out_addr == '0));

    assert_link_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind != 2'd2) |=> (out_link == '0));

    assert_wide_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_narrow && in_addr[1:0] != 2'b00) |=> out_fault);

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_pc) && $stable(out_addr) && $stable(out_link)));
endmodule

bind pcrel_addr_gen pcrel_addr_gen_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) chk_i (.*);

// File: tb/pcrel_addr_gen_tb_top.sv
`timescale 1ns/1ps
module pcrel_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        in_narrow = 1'b0;
    logic [1:0]  in_kind = '0;
    logic [11:0] in_imm = '0;
    logic        in_sub = 1'b0;
    logic        out_valid;
    logic [31:0] out_pc;
    logic [31:0] out_addr;
    logic [31:0] out_link;
    logic        out_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcrel_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_narrow(in_narrow), .in_kind(in_kind), .in_imm(in_imm), .in_sub(in_sub),
        .out_valid(out_valid), .out_pc(out_pc), .out_addr(out_addr),
        .out_link(out_link), .out_fault(out_fault)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Send one request, then check results after the capturing edge.
    task automatic run_one(input logic [31:0] a, input logic nar, input logic [1:0] k,
                           input logic [11:0] imm, input logic sb);
        logic [31:0] pc, base, ea, lnk;
        logic        flt;
        pc   = a + (nar ? 32'd4 : 32'd8);
        base = {pc[31:2], 2'b00};
        ea   = sb ? base - {20'd0, imm} : base + {20'd0, imm};
        lnk  = nar ? (pc | 32'd1) : ((a + 32'd4) & ~32'd1);
        flt  = nar ? a[0] : (a[1:0] != 2'b00);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_narrow = nar; in_kind = k; in_imm = imm; in_sub = sb;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 valid", {31'd0, out_valid}, 32'd1);
        chk(nar ? "R2 pc" : "R1 pc", out_pc, pc);
        chk(k == 2'd1 ? "R3 literal" : "R4 addr zero", out_addr, (k == 2'd1) ? ea : 32'd0);
        chk("R5 link", out_link, (k == 2'd2) ? lnk : 32'd0);
        chk("R6 fault", {31'd0, out_fault}, {31'd0, flt});
        // Idle cycle with scrambled inputs: everything must hold.
        in_addr = ~a; in_narrow = ~nar; in_kind = ~k; in_imm = ~imm; in_sub = ~sb;
        @(negedge clk);
        chk("R8 valid drop", {31'd0, out_valid}, 32'd0);
        chk("R10 hold pc", out_pc, pc);
        chk("R10 hold addr", out_addr, (k == 2'd1) ? ea : 32'd0);
    endtask

    initial begin
        logic [31:0] addrs [8];
        logic [11:0] imms [6];
        addrs = '{32'h0000159A, 32'h000015A0, 32'h000015AC, 32'h00001598,
                  32'h00001001, 32'h00001003, 32'hFFFFFFFC, 32'hFFFFFFFE};
        imms  = '{12'h000, 12'h001, 12'h003, 12'h004, 12'h338, 12'hFFF};
        // R9: request during reset must not raise valid.
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // Worked examples from the compressed state.
        run_one(32'h0000159A, 1'b1, 2'd1, 12'd0, 1'b0);
        chk("R3 example 159C", out_addr, 32'h0000159C);
        run_one(32'h000015A0, 1'b1, 2'd1, 12'd1, 1'b1);
        chk("R3 example 15A3", out_addr, 32'h000015A3);
        run_one(32'h000015AC, 1'b1, 2'd1, 12'd4, 1'b1);
        chk("R3 example 15AC", out_addr, 32'h000015AC);
        // R7: wrap past the top of the address space.
        run_one(32'hFFFFFFFC, 1'b0, 2'd0, 12'd0, 1'b0);
        chk("R7 wrap pc", out_pc, 32'h00000004);
        // Sweep.
        foreach (addrs[i])
            for (int nar = 0; nar < 2; nar++)
                for (int k = 0; k < 4; k++)
                    for (int sb = 0; sb < 2; sb++)
                        foreach (imms[j])
                            run_one(addrs[i], nar[0], k[1:0], imms[j], sb[0]);
        // R9: synchronous reset drops valid in the cycle after it is sampled.
        @(negedge clk);
        in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset mid-run", {31'd0, out_valid}, 32'd0);
        in_valid = 1'b0; rst_n = 1'b1;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule